// File: doc/BRIEF.md
# SDRAM Single-Bank Command Legality Monitor

This block watches the command pins of an SDRAM interface from the side and models one bank. On every clock it decodes chip select, row strobe, column strobe and write enable into a command code. It then decides whether that command is permitted in the state the bank is in. Accepted commands move the bank between its states. Timed states are left when a down-counter runs out. The block never drives the memory bus.

A command that breaks the rules for the current state raises a one-cycle flag in the same cycle the command is on the pins. The modelled bank ignores that command. Commands are only judged when clock enable was high in the cycle before. Commands that carry a bank address for a different bank are ignored. Six commands apply to every bank: deselect, no-operation, burst stop, precharge-all, refresh and mode-register set.

All recovery windows are parameters counted in clock cycles. An instance is placed once per bank, with the bank's index as a parameter.

Top module: `sdram_bank_monitor`

## Requirements
- R1: `cmd_o` gives the decoded command each cycle from {cs_n,ras_n,cas_n,we_n}. The codes are:
  - 0 deselect (cs_n high)
  - 1 NOP (0111)
  - 2 burst stop (0110)
  - 3 READ (0101)
  - 4 WRITE (0100)
  - 5 ACT (0011)
  - 6 PRE (0010)
  - 7 REF (0001)
  - 8 MRS (0000)
- R2: `state_o` uses the codes 0 idle, 1 row active, 2 write recovery, 3 write recovery with auto-precharge, 4 precharging, 5 refreshing and 6 mode-register access. While `rst` is high, and after it, the state is 0 and `illegal_o` is low.
- R3: When `cke` was low at the previous clock edge, no command is judged. `illegal_o` stays low and no command changes the state, but running timers keep counting.
- R4: READ, WRITE, ACT and PRE with `a10` low apply only when `ba` equals BANK_IDX. Otherwise they are ignored and never illegal. Deselect, NOP, burst stop, PRE with `a10` high (all banks), REF and MRS always apply.
- R5: In idle, READ and WRITE are illegal. ACT moves to row active. REF moves to refreshing. MRS moves to mode-register access. PRE, NOP, deselect and burst stop have no effect.
- R6: In row active, ACT, REF and MRS are illegal. WRITE enters write recovery, or write recovery with auto-precharge when `a10` is high. PRE moves to precharging.
- R7: Write recovery lasts BURST_LEN-1+T_DPL cycles after the write and then returns to row active. A READ or a new WRITE is accepted, with `a10` choosing auto-precharge. ACT, PRE, REF and MRS are illegal.
- R8: Write recovery with auto-precharge lasts BURST_LEN-1+T_DPL cycles and then enters precharging. Only deselect, NOP and burst stop are legal.
- R9: Precharging lasts T_RP cycles and then returns to idle. PRE is accepted with no effect. READ, WRITE, ACT, REF and MRS are illegal.
- R10: Refreshing lasts T_RC cycles and then returns to idle. Only deselect, NOP and burst stop are legal.
- R11: Mode-register access lasts T_MRD cycles and then returns to idle. Only deselect and NOP are legal; burst stop is illegal.
- R12: `illegal_o` is high only in the cycle the offending command is on the pins. The state ignores that command, and any running timer keeps counting as if a NOP had been given.
- R13: A READ accepted in row active or write recovery returns to row active when `a10` is low. When `a10` is high it enters precharging for BURST_LEN-1+T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: auto-precharge or all-banks select |
| state_o | output | 3 | Modelled bank state (R2 codes) |
| illegal_o | output | 1 | Pulse marking an illegal command this cycle |
| cmd_o | output | 4 | Decoded command (R1 codes) |

## Verification
Directed sequences step the bank through every state. In each state, every illegal command is tried, so a wrong entry in a single legality row shows up. Writes with and without `a10` tell the two recovery flavours apart by their exit state. Timed exits are checked on the exact cycle, which catches off-by-one counter loads.

Commands aimed at another bank, and cycles that follow a low `cke`, must leave both the flag and the state untouched. These cases separate bank matching and enable gating from the legality rules. A long seeded random run then mixes commands, bank addresses, `a10` and `cke`. It hits illegal commands issued in the middle of timed windows, where the timer must keep running.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [3:0] {
        C_DESL  = 4'd0,
        C_NOP   = 4'd1,
        C_BST   = 4'd2,
        C_READ  = 4'd3,
        C_WRITE = 4'd4,
        C_ACT   = 4'd5,
        C_PRE   = 4'd6,
        C_REF   = 4'd7,
        C_MRS   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ACTIVE = 3'd1,
        S_WREC   = 3'd2,
        S_WRECAP = 3'd3,
        S_PRECHG = 3'd4,
        S_REFSH  = 3'd5,
        S_MRSACC = 3'd6
    } bstate_e;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = C_DESL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = C_NOP;
                3'b110:  c = C_BST;
                3'b101:  c = C_READ;
                3'b100:  c = C_WRITE;
                3'b011:  c = C_ACT;
                3'b010:  c = C_PRE;
                3'b001:  c = C_REF;
                default: c = C_MRS;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_quiet(input cmd_e c);
        return (c == C_DESL) || (c == C_NOP) || (c == C_BST);
    endfunction

    function automatic logic cmd_allowed(input bstate_e s, input cmd_e c);
        logic ok;
        case (s)
            S_IDLE:   ok = !((c == C_READ) || (c == C_WRITE));
            S_ACTIVE: ok = !((c == C_ACT) || (c == C_REF) || (c == C_MRS));
            S_WREC:   ok = is_quiet(c) || (c == C_READ) || (c == C_WRITE);
            S_WRECAP: ok = is_quiet(c);
            S_PRECHG: ok = is_quiet(c) || (c == C_PRE);
            S_REFSH:  ok = is_quiet(c);
            S_MRSACC: ok = (c == C_DESL) || (c == C_NOP);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic is_timed(input bstate_e s);
        return (s == S_WREC) || (s == S_WRECAP) || (s == S_PRECHG) ||
               (s == S_REFSH) || (s == S_MRSACC);
    endfunction

    function automatic bstate_e exit_of(input bstate_e s);
        bstate_e n;
        case (s)
            S_WREC:   n = S_ACTIVE;
            S_WRECAP: n = S_PRECHG;
            default:  n = S_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sbm_decode.sv
module sbm_decode
    import sbm_pkg::*;
#(
    parameter int BA_W     = 2,
    parameter int BANK_IDX = 0
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output cmd_e            cmd,
    output logic            hit
);
    logic bank_scoped;

    always_comb begin
        cmd = decode_pins(cs_n, ras_n, cas_n, we_n);
        bank_scoped = (cmd == C_READ) || (cmd == C_WRITE) || (cmd == C_ACT) ||
                      ((cmd == C_PRE) && !a10);
        hit = bank_scoped ? (ba == BA_W'(BANK_IDX)) : 1'b1;
    end
endmodule

// File: rtl/sbm_timer.sv
module sbm_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/sbm_rules.sv
module sbm_rules
    import sbm_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int WR_CYC  = 5,
    parameter int RDA_CYC = 6,
    parameter int T_RP    = 3,
    parameter int T_RC    = 7,
    parameter int T_MRD   = 2
) (
    input  bstate_e          state,
    input  cmd_e             cmd,
    input  logic             a10,
    input  logic             eval,
    input  logic             hit,
    input  logic             expire,
    output logic             illegal,
    output logic             change,
    output bstate_e          nxt,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    logic ok;
    logic take;

    always_comb begin
        ok       = cmd_allowed(state, cmd);
        illegal  = eval && hit && !ok;
        take     = eval && hit && ok;
        change   = 1'b0;
        nxt      = state;
        load     = 1'b0;
        load_val = '0;

        if (expire && is_timed(state)) begin
            change = 1'b1;
            nxt    = exit_of(state);
            load   = 1'b1;
            load_val = (state == S_WRECAP) ? CNT_W'(T_RP) : '0;
        end

        if (take) begin
            case (state)
                S_IDLE: begin
                    if (cmd == C_ACT) begin
                        change = 1'b1; nxt = S_ACTIVE; load = 1'b1; load_val = '0;
                    end else if (cmd == C_REF) begin
                        change = 1'b1; nxt = S_REFSH; load = 1'b1; load_val = CNT_W'(T_RC);
                    end else if (cmd == C_MRS) begin
                        change = 1'b1; nxt = S_MRSACC; load = 1'b1; load_val = CNT_W'(T_MRD);
                    end
                end
                S_ACTIVE, S_WREC: begin
                    if (cmd == C_READ) begin
                        change = 1'b1; load = 1'b1;
                        nxt      = a10 ? S_PRECHG : S_ACTIVE;
                        load_val = a10 ? CNT_W'(RDA_CYC) : '0;
                    end else if (cmd == C_WRITE) begin
                        change = 1'b1; load = 1'b1;
                        nxt      = a10 ? S_WRECAP : S_WREC;
                        load_val = CNT_W'(WR_CYC);
                    end else if (cmd == C_PRE) begin
                        change = 1'b1; nxt = S_PRECHG; load = 1'b1; load_val = CNT_W'(T_RP);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sbm_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BANK_IDX  = 1,
    parameter int BURST_LEN = 4,
    parameter int T_DPL     = 2,
    parameter int T_RP      = 3,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic [2:0]      state_o,
    output logic            illegal_o,
    output logic [3:0]      cmd_o
);
    localparam int WR_CYC  = BURST_LEN - 1 + T_DPL;
    localparam int RDA_CYC = BURST_LEN - 1 + T_RP;
    localparam int MAX_A   = (WR_CYC > RDA_CYC) ? WR_CYC : RDA_CYC;
    localparam int MAX_B   = (T_RC > T_MRD) ? T_RC : T_MRD;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    bstate_e          state;
    bstate_e          nxt;
    cmd_e             cmd;
    logic             hit;
    logic             cke_q;
    logic             expire;
    logic             change;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             illegal;

    sbm_decode #(.BA_W(BA_W), .BANK_IDX(BANK_IDX)) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .cmd(cmd), .hit(hit)
    );

    sbm_rules #(
        .CNT_W(CNT_W), .WR_CYC(WR_CYC), .RDA_CYC(RDA_CYC),
        .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
    ) u_rules (
        .state(state), .cmd(cmd), .a10(a10), .eval(cke_q), .hit(hit),
        .expire(expire), .illegal(illegal), .change(change), .nxt(nxt),
        .load(load), .load_val(load_val)
    );

    sbm_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cke_q <= 1'b0;
        end else begin
            cke_q <= cke;
            if (change) state <= nxt;
        end
    end

    assign state_o   = state;
    assign illegal_o = illegal;
    assign cmd_o     = cmd;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker
    import sbm_pkg::*;
#(
    parameter int BA_W     = 2,
    parameter int BANK_IDX = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            cke,
    input logic [BA_W-1:0] ba,
    input logic [2:0]      state_o,
    input logic            illegal_o,
    input logic [3:0]      cmd_o
);
    assert_cke_gate_R3: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(cke));

    assert_hold_active_R12: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && state_o == 3'(S_ACTIVE)) |=> (state_o == 3'(S_ACTIVE)));

    assert_idle_rw_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(S_IDLE) && (cmd_o == 4'(C_READ) || cmd_o == 4'(C_WRITE)) &&
         ba == BA_W'(BANK_IDX) && $past(cke)) |-> illegal_o);

    assert_other_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'(C_ACT) && ba != BA_W'(BANK_IDX)) |-> !illegal_o);

    assert_wrap_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(S_WRECAP)) |=>
        (state_o == 3'(S_WRECAP) || state_o == 3'(S_PRECHG)));

    assert_wrap_read_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(S_WRECAP) && cmd_o == 4'(C_READ) &&
         ba == BA_W'(BANK_IDX) && $past(cke)) |-> illegal_o);

    assert_ref_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(S_REFSH)) |=>
        (state_o == 3'(S_REFSH) || state_o == 3'(S_IDLE)));

    assert_mrs_exit_R11: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(S_MRSACC)) |=>
        (state_o == 3'(S_MRSACC) || state_o == 3'(S_IDLE)));

    assert_mrs_bst_R11: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'(S_MRSACC) && cmd_o == 4'(C_BST) && $past(cke)) |-> illegal_o);
endmodule

bind sdram_bank_monitor sbm_checker #(.BA_W(BA_W), .BANK_IDX(BANK_IDX)) u_chk (
    .clk(clk), .rst(rst), .cke(cke), .ba(ba),
    .state_o(state_o), .illegal_o(illegal_o), .cmd_o(cmd_o)
);

// File: tb/sim_sdram_bank_monitor.sv
`timescale 1ns/1ps
module sim_sdram_bank_monitor;
    localparam int IDX = 1;
    localparam int BL = 4, TDPL = 2, TRP = 3, TRC = 7, TMRD = 2;
    localparam int WRC = BL - 1 + TDPL;
    localparam int RDAC = BL - 1 + TRP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic a10 = 1'b0;
    logic [2:0] state_o;
    logic illegal_o;
    logic [3:0] cmd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model
    int m_st = 0;
    int m_cnt = 0;
    bit m_ckeq = 0;

    always #5 clk = ~clk;

    sdram_bank_monitor #(.BA_W(2), .BANK_IDX(IDX), .BURST_LEN(BL), .T_DPL(TDPL),
                         .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)) u0 (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .state_o(state_o), .illegal_o(illegal_o),
        .cmd_o(cmd_o)
    );

    function automatic logic [3:0] pins_of(int c);
        case (c)
            0: return 4'b1111;
            1: return 4'b0111;
            2: return 4'b0110;
            3: return 4'b0101;
            4: return 4'b0100;
            5: return 4'b0011;
            6: return 4'b0010;
            7: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic bit exp_ok(int s, int c);
        case (s)
            0: return !(c == 3 || c == 4);
            1: return !(c == 5 || c == 7 || c == 8);
            2: return c <= 4;
            3: return c <= 2;
            4: return c <= 2 || c == 6;
            5: return c <= 2;
            6: return c <= 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_hit(int c, int b, bit a);
        bit scoped = (c == 3 || c == 4 || c == 5 || (c == 6 && !a));
        return scoped ? (b == IDX) : 1'b1;
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R8";
            4: return "R9";
            5: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // advance model by one clock edge with the current inputs
    task automatic model_edge(int c, int b, bit a, bit k);
        bit ill;
        bit take;
        int ns;
        int nc;
        ill  = m_ckeq && exp_hit(c, b, a) && !exp_ok(m_st, c);
        take = m_ckeq && exp_hit(c, b, a) && exp_ok(m_st, c);
        ns = m_st;
        nc = (m_cnt > 0) ? m_cnt - 1 : 0;
        if (m_cnt == 1 && m_st >= 2) begin
            case (m_st)
                2: begin ns = 1; nc = 0; end
                3: begin ns = 4; nc = TRP; end
                default: begin ns = 0; nc = 0; end
            endcase
        end
        if (take) begin
            if (m_st == 0) begin
                if (c == 5) begin ns = 1; nc = 0; end
                else if (c == 7) begin ns = 5; nc = TRC; end
                else if (c == 8) begin ns = 6; nc = TMRD; end
            end else if (m_st == 1 || m_st == 2) begin
                if (c == 3) begin ns = a ? 4 : 1; nc = a ? RDAC : 0; end
                else if (c == 4) begin ns = a ? 3 : 2; nc = WRC; end
                else if (c == 6) begin ns = 4; nc = TRP; end
            end
        end
        if (ill) begin end
        m_st = ns;
        m_cnt = nc;
        m_ckeq = k;
    endtask

    task automatic step(int c, int b, bit a, bit k, string tag);
        bit exp_ill;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = pins_of(c);
        ba = 2'(b);
        a10 = a;
        cke = k;
        #3;
        exp_ill = m_ckeq && exp_hit(c, b, a) && !exp_ok(m_st, c);
        check(cmd_o == 4'(c), "R1", "cmd_o", int'(cmd_o), c);
        check(state_o == 3'(m_st), tag, "state_o", int'(state_o), m_st);
        check(illegal_o == exp_ill, exp_ill ? "R12" : tag, "illegal_o", int'(illegal_o), int'(exp_ill));
        model_edge(c, b, a, k);
    endtask

    task automatic idle_n(int n, string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 1, tag);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // reset state R2
        repeat (3) @(negedge clk);
        #3;
        check(state_o == 3'd0, "R2", "reset state", int'(state_o), 0);
        check(illegal_o == 1'b0, "R2", "reset illegal", int'(illegal_o), 0);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_cnt = 0; m_ckeq = 1;
        #3;
        check(state_o == 3'd0, "R2", "state after reset", int'(state_o), 0);

        // R5 idle: illegal read/write, ACT opens row
        idle_n(1, "R5");
        step(3, IDX, 0, 1, "R5");
        step(4, IDX, 0, 1, "R5");
        step(6, IDX, 0, 1, "R5");
        // R4 other bank ACT ignored
        step(5, 2, 0, 1, "R4");
        step(3, 0, 0, 1, "R4");
        step(1, 0, 0, 1, "R4");
        step(5, IDX, 0, 1, "R5");
        // R6 active: ACT/REF/MRS illegal
        step(5, IDX, 0, 1, "R6");
        step(7, 0, 0, 1, "R6");
        step(8, 0, 0, 1, "R6");
        // R7 write recovery and exit
        step(4, IDX, 0, 1, "R7");
        step(6, IDX, 0, 1, "R7");
        step(6, 0, 1, 1, "R7");
        step(7, 0, 0, 1, "R7");
        step(8, 0, 0, 1, "R7");
        idle_n(WRC, "R7");
        // R13 read with AP from active
        step(3, IDX, 1, 1, "R13");
        step(5, IDX, 0, 1, "R9");
        step(6, IDX, 0, 1, "R9");
        idle_n(RDAC, "R13");
        // R10 refresh
        step(7, 3, 0, 1, "R10");
        step(2, 0, 0, 1, "R10");
        step(6, 0, 1, 1, "R10");
        step(5, IDX, 0, 1, "R10");
        idle_n(TRC, "R10");
        // R11 MRS
        step(8, 0, 0, 1, "R11");
        step(2, 0, 0, 1, "R11");
        idle_n(TMRD + 1, "R11");
        // R8 write with AP
        step(5, IDX, 0, 1, "R6");
        step(4, IDX, 1, 1, "R8");
        step(3, IDX, 0, 1, "R8");
        step(4, IDX, 0, 1, "R8");
        step(6, 0, 1, 1, "R8");
        idle_n(WRC + TRP + 1, "R8");
        // R3 cke low suppresses judging
        step(5, IDX, 0, 1, "R6");
        step(1, 0, 0, 0, "R3");
        step(5, IDX, 0, 1, "R3");
        step(8, 0, 0, 1, "R3");
        step(6, IDX, 0, 1, "R3");
        idle_n(TRP + 1, "R9");
        // R7 write then read without AP
        step(5, IDX, 0, 1, "R6");
        step(4, IDX, 0, 1, "R7");
        step(3, IDX, 0, 1, "R13");
        step(6, 0, 1, 1, "R9");
        idle_n(TRP + 1, "R9");

        // seeded random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            int c;
            int b;
            bit a;
            bit k;
            r = int'($urandom_range(0, 99));
            if (r < 20) c = 1;
            else if (r < 25) c = 0;
            else if (r < 30) c = 2;
            else if (r < 42) c = 3;
            else if (r < 56) c = 4;
            else if (r < 70) c = 5;
            else if (r < 82) c = 6;
            else if (r < 91) c = 7;
            else c = 8;
            b = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 3)) : IDX;
            a = 1'($urandom_range(0, 1));
            k = ($urandom_range(0, 9) != 0);
            step(c, b, a, k, tag_of(m_st));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule